// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch

A non-blocking crosspoint that connects a set of single-bit synchronous input lanes to an equal number of output lanes. Every output owns a private selector, so any input may feed one, several or all outputs at once. The lane each output follows is stored in an active route register. Software, or a sequencer, never writes the active registers directly.

Routing changes go through a second bank of staging registers. A write strobe stores an input number into the staging entry named by an output number. Any number of writes may be queued that way while the live routing stays as it is. A commit strobe then moves the whole staging bank into the active bank on one clock edge. A preset strobe overwrites both banks with one of two fixed patterns. With commit low the pattern is broadcast: every output follows input 0. With commit high it is pass-through: output i follows input i. A read-back port shows the staged and active select of any one output.

Top module: `xpoint_switch`

## Requirements
- R1: Each output lane is registered: on every edge where `rst_n` is high, `dout[i]` takes the value that `din[active select of i]` had just before that edge.
- R2: Port numbers on `in_addr` and `out_addr` are plain binary (0 means lane 0, 15 means lane 15). With `wr_stb` high and `preset` low, the edge stores `in_addr` into the staging entry numbered `out_addr`. No other entry changes.
- R3: A staging entry keeps its value on every edge where it is neither written nor preset.
- R4: Staging writes leave the live routing alone. The active bank changes only on an edge with `commit` or `preset` high.
- R5: With `commit` high and `preset` low, all active entries take their staging values on the same edge.
- R6: When `wr_stb` and `commit` are high together, the write is applied first, and the active entry receives the newly written value.
- R7: `preset` high with `commit` low loads 0 into every staging and every active entry (broadcast).
- R8: `preset` high with `commit` high loads i into staging and active entry i for every i (pass-through).
- R9: A write strobe during a preset is ignored: afterwards the staging bank holds the preset pattern only.
- R10: A low `rst_n` on a clock edge clears every staging entry, every active entry and every output lane to 0.
- R11: An output whose active select is the same before and after a commit keeps following its input, with no missed or stale bit across the commit edge.
- R12: `rb_staged` and `rb_active` show, without delay, the staging and active select of the output numbered `rb_port`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset to broadcast routing |
| preset | input | 1 | Preset strobe; the level of `commit` picks the pattern |
| wr_stb | input | 1 | Staging write strobe |
| commit | input | 1 | Copy the staging bank into the active bank |
| in_addr | input | 4 | Input lane number to store |
| out_addr | input | 4 | Output whose staging entry is written |
| din | input | 16 | Input data lanes |
| dout | output | 16 | Output data lanes, one register stage |
| rb_port | input | 4 | Output whose selects are shown on read-back |
| rb_staged | output | 4 | Staging select of output `rb_port` |
| rb_active | output | 4 | Active select of output `rb_port` |

## Verification
A behavioural model of both banks predicts every output lane and both read-back values on every cycle under random lane data. The bench queues writes without a commit, and a design that leaked staging into the live path would show a changed output there. It issues a write and a commit in one cycle, where a design that committed the stale value would read back the old select. It sends presets of both polarities with a write strobe held high, which catches a swapped pattern, a preset that misses one bank, or a write that slips through. It also commits a bank in which some selects are unchanged while their inputs toggle every cycle, so a lane that drops or repeats a bit across the commit is reported.

// File: rtl/xps_pkg.sv
// Package: shared types and helpers for the crosspoint switch.
// Assumes: port numbers are non-negative integers below the lane count.
package xps_pkg;

    // Preset patterns, encoded by the level of the commit strobe
    typedef enum logic {
        XPS_BROADCAST = 1'b0,
        XPS_PASS      = 1'b1
    } xps_preset_e;

    // Select value that a preset places in entry idx
    function automatic int unsigned xps_preset_sel(input int unsigned idx,
                                                   input xps_preset_e mode);
        return (mode == XPS_PASS) ? idx : 0;
    endfunction

endpackage

// File: rtl/xps_stage_bank.sv
// Module: staging bank. One select entry per output, written one at a
// time through an output-number decoder, or all at once by a preset.
// Assumes: preset has priority over the write strobe. The next-state
// value is exported so a same-cycle commit can carry a fresh write.
module xps_stage_bank
    import xps_pkg::*;
#(
    parameter int N_PORTS = 16,
    localparam int SEL_W  = $clog2(N_PORTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          preset,
    input  logic                          commit,
    input  logic                          wr_stb,
    input  logic [SEL_W-1:0]              in_addr,
    input  logic [SEL_W-1:0]              out_addr,
    output logic [N_PORTS-1:0][SEL_W-1:0] stage_d,
    output logic [N_PORTS-1:0][SEL_W-1:0] stage_q
);

    xps_preset_e mode;
    assign mode = xps_preset_e'(commit);

    // Next-state: preset pattern, decoded write, or hold
    always_comb begin
        for (int i = 0; i < N_PORTS; i++) begin
            if (preset) begin
                stage_d[i] = SEL_W'(xps_preset_sel(i, mode));
            end else if (wr_stb && (out_addr == SEL_W'(i))) begin
                stage_d[i] = in_addr;
            end else begin
                stage_d[i] = stage_q[i];
            end
        end
    end

    // Staging storage with synchronous clear to broadcast
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_chk
        p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stb && !preset && out_addr == SEL_W'(gi)) |=> stage_q[gi] == $past(in_addr));
        p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!preset && !(wr_stb && out_addr == SEL_W'(gi))) |=> $stable(stage_q[gi]));
        p_bcast_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (preset && !commit) |=> stage_q[gi] == '0);
        p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (preset && commit) |=> stage_q[gi] == SEL_W'(gi));
    end

endmodule

// File: rtl/xps_active_bank.sv
// Module: active route bank. Holds the select each output lane follows.
// Loads the staging next-state on commit or preset, otherwise holds.
// Assumes: the staging next-state already carries the preset pattern
// and any write from the same cycle.
module xps_active_bank #(
    parameter int N_PORTS = 16,
    localparam int SEL_W  = $clog2(N_PORTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          preset,
    input  logic                          commit,
    input  logic [N_PORTS-1:0][SEL_W-1:0] stage_d,
    output logic [N_PORTS-1:0][SEL_W-1:0] act_q
);

    logic take;
    assign take = preset || commit;

    // Active storage: transfer all entries together or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (take) begin
            act_q <= stage_d;
        end
    end

    p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset && !commit) |=> $stable(act_q));
    p_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !preset) |=> act_q == $past(stage_d));
    p_bcast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (preset && !commit) |=> act_q == '0);

endmodule

// File: rtl/xps_lane.sv
// Module: one output lane. A selector over all inputs followed by a
// single register stage.
// Assumes: the select is stable except on commit or preset edges.
module xps_lane #(
    parameter int N_PORTS = 16,
    localparam int SEL_W  = $clog2(N_PORTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PORTS-1:0] din,
    input  logic [SEL_W-1:0]   sel,
    output logic               dout
);

    // Lane register: sample the selected input every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= 1'b0;
        end else begin
            dout <= din[sel];
        end
    end

    p_route_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> dout == $past(din[sel]));

endmodule

// File: rtl/xpoint_switch.sv
// Module: top of the double-buffered crosspoint. Joins the staging
// bank, the active bank, one lane per output and the read-back selector.
// Assumes: control inputs are synchronous to clk. Reset gives broadcast.
module xpoint_switch #(
    parameter int N_PORTS = 16,
    localparam int SEL_W  = $clog2(N_PORTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               preset,
    input  logic               wr_stb,
    input  logic               commit,
    input  logic [SEL_W-1:0]   in_addr,
    input  logic [SEL_W-1:0]   out_addr,
    input  logic [N_PORTS-1:0] din,
    output logic [N_PORTS-1:0] dout,
    input  logic [SEL_W-1:0]   rb_port,
    output logic [SEL_W-1:0]   rb_staged,
    output logic [SEL_W-1:0]   rb_active
);

    logic [N_PORTS-1:0][SEL_W-1:0] stage_d;
    logic [N_PORTS-1:0][SEL_W-1:0] stage_q;
    logic [N_PORTS-1:0][SEL_W-1:0] act_q;

    xps_stage_bank #(.N_PORTS(N_PORTS)) i_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .preset   (preset),
        .commit   (commit),
        .wr_stb   (wr_stb),
        .in_addr  (in_addr),
        .out_addr (out_addr),
        .stage_d  (stage_d),
        .stage_q  (stage_q)
    );

    xps_active_bank #(.N_PORTS(N_PORTS)) i_active (
        .clk     (clk),
        .rst_n   (rst_n),
        .preset  (preset),
        .commit  (commit),
        .stage_d (stage_d),
        .act_q   (act_q)
    );

    for (genvar go = 0; go < N_PORTS; go++) begin : g_lane
        xps_lane #(.N_PORTS(N_PORTS)) i_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (din),
            .sel   (act_q[go]),
            .dout  (dout[go])
        );
    end

    // Read-back selector over both banks
    always_comb begin
        rb_staged = stage_q[rb_port];
        rb_active = act_q[rb_port];
    end

    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> (act_q == '0 && stage_q == '0 && dout == '0));
    p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (preset && commit) |=> act_q == $past(stage_d));
    p_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && commit && !preset) |=> act_q[$past(out_addr)] == $past(in_addr));

endmodule

// File: tb/test_xpoint_switch.sv
`timescale 1ns/1ps
module test_xpoint_switch;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n, preset, wr_stb, commit;
    logic [3:0]  in_addr, out_addr, rb_port;
    logic [N-1:0] din, dout;
    logic [3:0]  rb_staged, rb_active;

    int stg [N];
    int act [N];
    logic [N-1:0] exp_dout;
    int rbp = 0;
    int n_vec = 0;
    int n_bad = 0;
    string cur_req = "R10";
    bit done = 0;

    always #2 clk = ~clk;

    xpoint_switch #(.N_PORTS(N)) i_xpoint_switch (
        .clk(clk), .rst_n(rst_n), .preset(preset), .wr_stb(wr_stb),
        .commit(commit), .in_addr(in_addr), .out_addr(out_addr),
        .din(din), .dout(dout), .rb_port(rb_port),
        .rb_staged(rb_staged), .rb_active(rb_active)
    );

    task automatic check(input string req, input string what, input int act_v, input int exp_v);
        n_vec++;
        if (act_v != exp_v) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act_v, exp_v);
        end
    endtask

    // One clock: drive at negedge, update the model at posedge, compare at next negedge
    task automatic cyc(input bit rn, input bit pr, input bit wr, input bit cm,
                       input int ia, input int oa, input logic [N-1:0] dv);
        rst_n = rn; preset = pr; wr_stb = wr; commit = cm;
        in_addr = 4'(ia); out_addr = 4'(oa); din = dv; rb_port = 4'(rbp);
        @(posedge clk);
        if (!rn) begin
            for (int i = 0; i < N; i++) begin stg[i] = 0; act[i] = 0; end
            exp_dout = '0;
        end else begin
            for (int i = 0; i < N; i++) exp_dout[i] = dv[act[i]];
            if (pr) begin
                for (int i = 0; i < N; i++) begin
                    stg[i] = cm ? i : 0;
                    act[i] = stg[i];
                end
            end else begin
                if (wr) stg[oa] = ia;
                if (cm) for (int i = 0; i < N; i++) act[i] = stg[i];
            end
        end
        @(negedge clk);
        check(cur_req, "dout", int'(dout), int'(exp_dout));
        check("R12", "rb_staged", int'(rb_staged), stg[rbp]);
        check("R12", "rb_active", int'(rb_active), act[rbp]);
        rbp = (rbp + 1) % N;
    endtask

    // Read back every output's selects through the port
    task automatic scan(input string req);
        for (int p = 0; p < N; p++) begin
            rb_port = 4'(p);
            #0.1;
            check(req, "scan staged", int'(rb_staged), stg[p]);
            check(req, "scan active", int'(rb_active), act[p]);
        end
    endtask

    initial begin : watchdog
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        rst_n = 0; preset = 0; wr_stb = 0; commit = 0;
        in_addr = 0; out_addr = 0; din = '0; rb_port = 0;
        @(negedge clk);
        // R10: reset clears everything to broadcast
        cur_req = "R10";
        cyc(0, 0, 0, 0, 0, 0, 16'hFFFF);
        cyc(0, 0, 1, 1, 5, 5, 16'hA5A5);
        scan("R10");
        // R1: broadcast routing with random data
        cur_req = "R1";
        for (int k = 0; k < 8; k++) cyc(1, 0, 0, 0, 0, 0, 16'($urandom));
        // R2, R3, R4: stage a reversed map, live routing unchanged
        cur_req = "R4";
        for (int o = 0; o < N; o++) cyc(1, 0, 1, 0, N - 1 - o, o, 16'($urandom));
        for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0, 3, 7, 16'($urandom));
        scan("R2");
        scan("R3");
        // R5: commit all at once
        cur_req = "R5";
        cyc(1, 0, 0, 1, 0, 0, 16'($urandom));
        for (int k = 0; k < 6; k++) cyc(1, 0, 0, 0, 0, 0, 16'($urandom));
        scan("R5");
        // R6: write and commit in one cycle
        cur_req = "R6";
        cyc(1, 0, 1, 1, 9, 4, 16'($urandom));
        scan("R6");
        cyc(1, 0, 0, 0, 0, 0, 16'($urandom));
        // R9 and R8: pass-through preset with a write strobe held high
        cur_req = "R8";
        cyc(1, 1, 1, 1, 12, 2, 16'($urandom));
        scan("R9");
        scan("R8");
        for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0, 0, 0, 16'($urandom));
        // R11: re-commit with some selects unchanged, toggling inputs
        cur_req = "R11";
        cyc(1, 0, 1, 0, 0, 1, 16'h5555);
        cyc(1, 0, 1, 0, 15, 14, 16'hAAAA);
        cyc(1, 0, 0, 1, 0, 0, 16'h5555);
        for (int k = 0; k < 6; k++) cyc(1, 0, 0, 0, 0, 0, (k % 2) ? 16'h5555 : 16'hAAAA);
        // R7 and R9: broadcast preset with a write strobe held high
        cur_req = "R7";
        cyc(1, 1, 1, 0, 6, 11, 16'($urandom));
        scan("R7");
        scan("R9");
        for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0, 0, 0, 16'($urandom));
        // R1: random mixed traffic
        cur_req = "R1";
        for (int k = 0; k < 300; k++)
            cyc(1, ($urandom % 40) == 0, ($urandom % 3) == 0, ($urandom % 7) == 0,
                int'($urandom % N), int'($urandom % N), 16'($urandom));
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule